// File: doc/BRIEF.md
# Exhaustive Memory Pattern Test Sequencer

This block is a self-running tester for a word-addressed memory behind a simple synchronous port with one cycle of read latency. After a start pulse it holds one address and walks a test word through every value the data width allows. For each value it writes the word, reads it back and subtracts the stored word from the read word. Once the test word rolls over from all ones to zero, the sequencer moves to the next address.

The sweep begins at a fixed nonzero base address. It ends when it has finished the address given on the top-address input, or the all-ones address, whichever comes first. The address register then reloads the base and `done` rises. A nonzero difference stops everything at once. The failing address, the word written and the word read stay latched and `fail` is held until the next start. Fault repair and remapping are outside the block.

Top module: `mem_pattern_tester`

## Requirements
- R1: While reset is held, and after its release until a start pulse, `busy`, `done`, `fail`, `mem_we_o` and `mem_re_o` are all low.
- R2: A start pulse seen while not busy loads the address with the base (BASE_ADDR, default 64) and the test word with zero. On the next cycle `busy` is high, and `done`, `fail` and the three failure-record outputs are cleared to zero.
- R3: Each test word takes exactly three cycles. First is a write cycle with `mem_we_o`=1, `mem_addr_o` set to the current address and `mem_wdata_o` set to the word. Next is a read cycle with `mem_re_o`=1 at the same address. Last is a compare cycle with both strobes low, in which `mem_rdata_i` carries the word read.
- R4: After a matching compare, the test word increases by one and the next write goes to the same address. As a result, the last word left at each tested address is all ones.
- R5: After the compare of the all-ones word, the test word returns to zero and the address increases by one.
- R6: The sweep finishes after the all-ones compare at the address equal to `top_addr_i`, or at the all-ones address. The address reloads the base, `busy` falls and `done` rises. Addresses outside the swept range are never written.
- R7: A compare with a nonzero difference stops the sweep after that compare cycle. `fail` goes high, and `fail_addr_o`, `fail_exp_o` and `fail_got_o` capture the address, the word written and the word read. No further memory strobes occur, and these outputs hold until the next start.
- R8: A start pulse while `busy` is high has no effect on the sweep, its length or its result.
- R9: If `top_addr_i` is below the base, the sweep runs up to the all-ones address and then finishes as in R6.
- R10: At most one of `busy`, `done` and `fail` is high at a time. `done` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse |
| top_addr_i | input | ADDR_W | Highest address to test |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe (data valid next cycle) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data (current test word) |
| mem_rdata_i | input | DATA_W | Memory read data |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished without a mismatch |
| fail_o | output | 1 | Halted on a mismatch |
| fail_addr_o | output | ADDR_W | Address of the mismatch |
| fail_exp_o | output | DATA_W | Word written at the mismatch |
| fail_got_o | output | DATA_W | Word read at the mismatch |

## Verification
The bench uses a narrow data width so that every sweep stays short. It drives the block against a memory model whose stuck-off bit masks are placed at chosen addresses. A fault at the first address, at a middle address and at the top address checks that the failure record reports the right address and the lowest word that exposes the stuck bit. The total number of busy cycles checks three cycles per word at every address before the failing one. A fault placed above the top address must pass, which shows the top limit is honoured. Top equal to the base, top at all ones and top below the base distinguish the two wrap conditions. A start pulse injected mid-sweep must leave the cycle count unchanged.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4,
    ST_HALT  = 3'd5
  } mts_state_e;

endpackage

// File: rtl/mts_rst_sync.sv
module mts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mts_addr_ctr.sv
module mts_addr_ctr #(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] top_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  assign last_o  = (addr_q == top_i) || (addr_q == ALL_ONES);
  assign addr_en = load_i | step_i;

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = BASE;
    end else if (step_i) begin
      addr_d = last_o ? BASE : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= BASE;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && last_o) |=> (addr_o == BASE));

  assert_addr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !last_o) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

endmodule

// File: rtl/mts_pattern_ctr.sv
module mts_pattern_ctr #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] value_o,
  output logic              max_o
);

  logic [DATA_W-1:0] value_q, value_d;
  logic              value_en;

  assign value_en = clear_i | step_i;
  assign max_o    = &value_q;

  always_comb begin
    value_d = value_q;
    if (clear_i) begin
      value_d = '0;
    end else if (step_i) begin
      value_d = value_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (value_en) begin
      value_q <= value_d;
    end
  end

  assign value_o = value_q;

  assert_value_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i) |=> (value_o == DATA_W'($past(value_o) + 1'b1)));

  assert_value_rollover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && max_o) |=> (value_o == '0));

endmodule

// File: rtl/mts_compare.sv
module mts_compare #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] expect_i,
  input  logic [DATA_W-1:0] got_i,
  output logic              mismatch_o
);

  logic [DATA_W-1:0] diff;

  assign diff       = got_i - expect_i;
  assign mismatch_o = |diff;

  always_comb begin
    assert_diff_means_unequal_R7: assert (mismatch_o == (got_i != expect_i));
  end

endmodule

// File: rtl/mts_ctrl.sv
module mts_ctrl
  import mts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mismatch_i,
  input  logic              val_max_i,
  input  logic              addr_last_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              load_o,
  output logic              val_step_o,
  output logic              addr_step_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);

  mts_state_e state_q, state_d;
  logic       capture;
  logic       rec_en;

  logic [ADDR_W-1:0] rec_addr_q, rec_addr_d;
  logic [DATA_W-1:0] rec_exp_q, rec_exp_d;
  logic [DATA_W-1:0] rec_got_q, rec_got_d;

  // next-state logic
  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    val_step_o  = 1'b0;
    addr_step_o = 1'b0;
    capture     = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE, ST_HALT: begin
        if (start_i) begin
          state_d = ST_WRITE;
          load_o  = 1'b1;
        end
      end
      ST_WRITE: state_d = ST_READ;
      ST_READ:  state_d = ST_CHECK;
      ST_CHECK: begin
        if (mismatch_i) begin
          state_d = ST_HALT;
          capture = 1'b1;
        end else begin
          val_step_o = 1'b1;
          if (val_max_i) begin
            addr_step_o = 1'b1;
            state_d     = addr_last_i ? ST_DONE : ST_WRITE;
          end else begin
            state_d = ST_WRITE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // failure record: cleared on start, captured on mismatch
  assign rec_en = load_o | capture;

  always_comb begin
    rec_addr_d = capture ? addr_i  : '0;
    rec_exp_d  = capture ? value_i : '0;
    rec_got_d  = capture ? rdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_addr_q <= '0;
      rec_exp_q  <= '0;
      rec_got_q  <= '0;
    end else if (rec_en) begin
      rec_addr_q <= rec_addr_d;
      rec_exp_q  <= rec_exp_d;
      rec_got_q  <= rec_got_d;
    end
  end

  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_re_o    = (state_q == ST_READ);
  assign busy_o      = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_CHECK);
  assign done_o      = (state_q == ST_DONE);
  assign fail_o      = (state_q == ST_HALT);
  assign fail_addr_o = rec_addr_q;
  assign fail_exp_o  = rec_exp_q;
  assign fail_got_o  = rec_got_q;

  assert_read_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (mem_re_o && (addr_i == $past(addr_i))));

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o) && $stable(fail_exp_o)
                              && $stable(fail_got_o)));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, fail_o}));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !load_o);

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int BASE_ADDR  = 64,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] top_addr_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);

  logic              rst_int_n;
  logic              load, val_step, addr_step;
  logic              val_max, addr_last, mismatch;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] value;

  mts_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mts_addr_ctr #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_addr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .step_i (addr_step),
    .top_i  (top_addr_i),
    .addr_o (addr),
    .last_o (addr_last)
  );

  mts_pattern_ctr #(.DATA_W(DATA_W)) u_pat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear_i (load),
    .step_i  (val_step),
    .value_o (value),
    .max_o   (val_max)
  );

  mts_compare #(.DATA_W(DATA_W)) u_cmp (
    .expect_i   (value),
    .got_i      (mem_rdata_i),
    .mismatch_o (mismatch)
  );

  mts_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .mismatch_i  (mismatch),
    .val_max_i   (val_max),
    .addr_last_i (addr_last),
    .addr_i      (addr),
    .value_i     (value),
    .rdata_i     (mem_rdata_i),
    .load_o      (load),
    .val_step_o  (val_step),
    .addr_step_o (addr_step),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o),
    .fail_got_o  (fail_got_o)
  );

  assign mem_addr_o  = addr;
  assign mem_wdata_o = value;

endmodule

// File: tb/mem_pattern_tester_test.sv
`timescale 1ns/1ps
module mem_pattern_tester_test;

  localparam int AW   = 8;
  localparam int DW   = 4;
  localparam int BASE = 64;
  localparam int NMEM = 1 << AW;
  localparam logic [DW-1:0] MARK = 4'h5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] top_addr = 8'd66;
  logic          we, re, busy, done, fail;
  logic [AW-1:0] addr, f_addr_o;
  logic [DW-1:0] wdata, rdata, f_exp_o, f_got_o;

  logic          init_req = 1'b0;
  logic          f_en = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0;
  logic [DW-1:0] mem [NMEM];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mem_pattern_tester #(.ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE)) uut (
    .clk (clk), .rst_n (rst_n), .start_i (start), .top_addr_i (top_addr),
    .mem_we_o (we), .mem_re_o (re), .mem_addr_o (addr), .mem_wdata_o (wdata),
    .mem_rdata_i (rdata), .busy_o (busy), .done_o (done), .fail_o (fail),
    .fail_addr_o (f_addr_o), .fail_exp_o (f_exp_o), .fail_got_o (f_got_o)
  );

  // memory model: one-cycle read latency, stuck-off bits at one address
  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < NMEM; i++) mem[i] <= MARK;
    end else if (we) begin
      mem[addr] <= (f_en && addr == f_addr) ? (wdata & ~f_mask) : wdata;
    end
    if (re) rdata <= mem[addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] top, input logic fen, input logic [AW-1:0] fa,
                     input logic [DW-1:0] fm, input bit poke, output int cyc);
    top_addr = top; f_en = fen; f_addr = fa; f_mask = fm;
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!(done || fail) && cyc < 20000) begin
      if (busy) cyc++;
      start = poke && (cyc == 50);
      @(negedge clk);
    end
    start = 1'b0;
    if (cyc >= 20000) chk(1'b0, "watchdog", cyc, 0);
  endtask

  typedef struct packed {
    logic [AW-1:0] top;
    logic          fen;
    logic [AW-1:0] fa;
    logic [DW-1:0] fm;
    logic          poke;
    logic          xfail;
    logic [AW-1:0] xaddr;
    logic [DW-1:0] xexp;
    logic [DW-1:0] xgot;
    logic [15:0]   xcyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd66,  1'b0, 8'd0,  4'h0, 1'b0, 1'b0, 8'd0,  4'd0, 4'd0, 16'd144},
    '{8'd64,  1'b0, 8'd0,  4'h0, 1'b0, 1'b0, 8'd0,  4'd0, 4'd0, 16'd48},
    '{8'd70,  1'b1, 8'd65, 4'h4, 1'b0, 1'b1, 8'd65, 4'd4, 4'd0, 16'd63},
    '{8'd70,  1'b1, 8'd64, 4'h1, 1'b0, 1'b1, 8'd64, 4'd1, 4'd0, 16'd6},
    '{8'd70,  1'b1, 8'd70, 4'h8, 1'b0, 1'b1, 8'd70, 4'd8, 4'd0, 16'd315},
    '{8'd66,  1'b1, 8'd67, 4'h1, 1'b0, 1'b0, 8'd0,  4'd0, 4'd0, 16'd144},
    '{8'd66,  1'b1, 8'd66, 4'hF, 1'b0, 1'b1, 8'd66, 4'd1, 4'd0, 16'd102},
    '{8'd255, 1'b0, 8'd0,  4'h0, 1'b0, 1'b0, 8'd0,  4'd0, 4'd0, 16'd9216},
    '{8'd10,  1'b0, 8'd0,  4'h0, 1'b0, 1'b0, 8'd0,  4'd0, 4'd0, 16'd9216},
    '{8'd66,  1'b0, 8'd0,  4'h0, 1'b1, 1'b0, 8'd0,  4'd0, 4'd0, 16'd144}
  };

  initial begin
    int cyc;
    logic [AW-1:0] hold_addr;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail, "R1 flags in reset", {busy, done, fail}, 0);
    chk(!we && !re, "R1 strobes in reset", {we, re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fail && !we && !re, "R1 idle after reset", {busy, done, fail, we, re}, 0);

    // R2/R3: first words of a sweep, cycle by cycle
    top_addr = 8'd64;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done && !fail, "R2 busy after start", {busy, done, fail}, 4);
    chk(we && !re && addr == 8'd64 && wdata == 4'd0, "R3 write cycle", {we, re, addr}, {1'b1, 1'b0, 8'd64});
    @(negedge clk);
    chk(re && !we && addr == 8'd64, "R3 read cycle", {we, re, addr}, {1'b0, 1'b1, 8'd64});
    @(negedge clk);
    chk(!re && !we, "R3 compare cycle", {we, re}, 0);
    @(negedge clk);
    chk(we && addr == 8'd64 && wdata == 4'd1, "R4 next word same address", {addr, wdata}, {8'd64, 4'd1});
    while (busy) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VECS[v].poke ? "R8" : (VECS[v].top < BASE) ? "R9" : VECS[v].xfail ? "R7" : "R6";
      run(VECS[v].top, VECS[v].fen, VECS[v].fa, VECS[v].fm, VECS[v].poke, cyc);
      chk(cyc == int'(VECS[v].xcyc), {tag, " R3 busy cycles"}, cyc, VECS[v].xcyc);
      chk(fail == VECS[v].xfail && done == !VECS[v].xfail, {tag, " outcome"}, {done, fail}, {!VECS[v].xfail, VECS[v].xfail});
      chk(f_addr_o == VECS[v].xaddr, {tag, " fail address"}, f_addr_o, VECS[v].xaddr);
      chk(f_exp_o == VECS[v].xexp, {tag, " fail expected word"}, f_exp_o, VECS[v].xexp);
      chk(f_got_o == VECS[v].xgot, {tag, " fail read word"}, f_got_o, VECS[v].xgot);
      if (!VECS[v].xfail) begin
        chk(mem[BASE] == 4'hF, "R4 final word all ones", mem[BASE], 15);
        chk(mem[BASE-1] == MARK, "R6 below base untouched", mem[BASE-1], MARK);
        if (VECS[v].top >= BASE && VECS[v].top != 8'd255)
          chk(mem[VECS[v].top + 1] == MARK, "R6 above top untouched", mem[VECS[v].top + 1], MARK);
      end
    end

    // R10: done holds
    run(8'd64, 1'b0, 8'd0, 4'h0, 1'b0, cyc);
    repeat (10) @(negedge clk);
    chk(done && !busy && !fail, "R10 done holds", {busy, done, fail}, 2);

    // R7: halt holds, no strobes; R2: start clears record
    run(8'd66, 1'b1, 8'd65, 4'h2, 1'b0, cyc);
    hold_addr = f_addr_o;
    begin
      int strobes = 0;
      for (int i = 0; i < 20; i++) begin
        if (we || re || !fail) strobes++;
        @(negedge clk);
      end
      chk(strobes == 0, "R7 halted quietly", strobes, 0);
    end
    chk(f_addr_o == 8'd65 && hold_addr == 8'd65 && f_exp_o == 4'd2, "R7 record held", f_addr_o, 65);
    top_addr = 8'd64; f_en = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !fail && f_addr_o == 0 && f_exp_o == 0 && f_got_o == 0, "R2 start clears record",
        {busy, fail, f_addr_o}, {1'b1, 1'b0, 8'd0});
    while (busy) @(negedge clk);
    chk(done, "R6 clean rerun", done, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule